// File: doc/BRIEF.md
# Periodic Stop-Mode Wake Timer

This block is a down-counting interval timer that advances on pulses from an always-on slow ring oscillator, nominally 8 kHz. The pulses reach the block as single-cycle strobes in its own clock domain. Software first stores an interval in a reload register. It then sets an enable bit. From that point the counter steps down by one on each ring tick.

When the programmed number of ticks has elapsed, the block sets a sticky interrupt flag. It refills the counter from the reload register and keeps going, so the flag comes back at a fixed period. The tick source and the counter both keep running while the device is in stop mode. The flag, gated by the stop-mode indication, forms a wake request. Software clears the flag by writing a 0 to it.

Top module: `wake_timer`

## Requirements
- R1: After reset the count is 0, the enable bit is 0, the interval register is 0, and the interrupt flag and wake request are both low.
- R2: A write to the enable bit with data 1 while the bit is 0 starts the timer. The count shows the interval register one cycle later, or the interval being written in that same cycle if there is one.
- R3: While enabled with a non-zero count, each cycle with `ring_tick` high lowers the count by one. Cycles without a tick leave the count unchanged.
- R4: With interval N (N ≥ 1), the interrupt flag rises in the cycle after the N-th tick counted from the start. In that same cycle the count is refilled with the interval register value.
- R5: The timer keeps counting after each expiry, so the flag condition repeats every N ticks for as long as the timer stays enabled.
- R6: A write of 0 to the enable bit stops counting and freezes the count. A later enable write of 1 restarts the count from the interval register.
- R7: With an interval of 0, enabling gives a count of 0 that stays at 0 on every tick, and the flag is never raised.
- R8: A write to the interval register while the timer runs leaves the current count untouched. The new value is used only at the next refill.
- R9: The interrupt flag stays high until a flag write with data 0 clears it. A flag write with data 1 does nothing. If a clear and an expiry fall in the same cycle, the flag ends high.
- R10: `stop_mode` has no effect on counting. `wake_req` is high exactly when the flag is high and `stop_mode` is high.
- R11: The largest interval, 2^CNT_W − 1 (65535 by default), expires after exactly that many ticks.
- R12: An enable write of 1 while already enabled does not restart the count. When a start and a tick fall in the same cycle, the start wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_tick | input | 1 | One-cycle strobe per slow ring oscillator period |
| stop_mode | input | 1 | High while the device is in stop mode |
| ivl_wr | input | 1 | Write strobe for the interval register |
| ivl_wdata | input | CNT_W | Interval value to store |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Enable bit value to store |
| flag_wr | input | 1 | Write strobe for the interrupt flag |
| flag_wdata | input | 1 | Flag write data (0 clears, 1 ignored) |
| irq_flag | output | 1 | Sticky interrupt flag |
| wake_req | output | 1 | Flag qualified by stop mode |
| count_val | output | CNT_W | Current counter value |
| enabled | output | 1 | Current enable bit |

## Verification
The bench instantiates the block with the default CNT_W of 16 and drives `ring_tick` on every cycle during the long runs. This makes the full 65535-tick interval, and the exact expiry edge at its end, reachable in about 65 thousand cycles. Intervals of 1, 2, 5 and 300 are walked through several expiries, which exercises the refill path and the wrap of the period. Directed cases cover the same-cycle collisions: start against tick, and clear against expiry.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  // What the counter does in a given cycle
  typedef enum logic [2:0] {
    CA_HOLD   = 3'd0,
    CA_LOAD   = 3'd1,
    CA_DEC    = 3'd2,
    CA_RELOAD = 3'd3,
    CA_IDLE   = 3'd4
  } cnt_act_e;
endpackage

// File: rtl/wkt_ctrl_regs.sv
module wkt_ctrl_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ivl_wr,
  input  logic [CNT_W-1:0] ivl_wdata,
  input  logic             en_wr,
  input  logic             en_wdata,
  output logic [CNT_W-1:0] reload_q,
  output logic             en_q,
  output logic             start,
  output logic [CNT_W-1:0] load_val
);
  // A start is the 0 -> 1 transition of the enable bit
  assign start    = en_wr && en_wdata && !en_q;
  assign load_val = ivl_wr ? ivl_wdata : reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      en_q     <= 1'b0;
    end else begin
      if (ivl_wr) reload_q <= ivl_wdata;
      if (en_wr)  en_q     <= en_wdata;
    end
  end

  // R2
  ivl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_wr |=> reload_q == $past(ivl_wdata));

  // R6
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !en_wdata) |=> !en_q);
endmodule

// File: rtl/wkt_down_counter.sv
module wkt_down_counter
  import wkt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en_q,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_act_e         act;
  logic [CNT_W-1:0] count_d;

  // Priority: start, then stopped, then idle at zero, then tick
  function automatic cnt_act_e pick_act(input logic st, input logic en,
                                        input logic tk,
                                        input logic [CNT_W-1:0] c);
    if (st)             return CA_LOAD;
    else if (!en)       return CA_HOLD;
    else if (c == '0)   return CA_IDLE;
    else if (!tk)       return CA_HOLD;
    else if (c == ONE)  return CA_RELOAD;
    else                return CA_DEC;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input cnt_act_e a,
                                                  input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] ld,
                                                  input logic [CNT_W-1:0] rl);
    case (a)
      CA_LOAD:   return ld;
      CA_DEC:    return c - ONE;
      CA_RELOAD: return rl;
      default:   return c;
    endcase
  endfunction

  always_comb begin
    act     = pick_act(start, en_q, tick, count_q);
    count_d = next_count(act, count_q, load_val, reload_val);
    expire  = (act == CA_RELOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !start && !tick) |=> $stable(count_q));

  // R3
  tick_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !start && tick && count_q > ONE) |=> count_q == $past(count_q) - ONE);

  // R6
  off_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !start) |=> $stable(count_q));

  // R7
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !start) |=> (count_q == '0 && !$past(expire)));

  // R4
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count_q == $past(reload_val));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count_q == $past(load_val));
endmodule

// File: rtl/wkt_irq_flag.sv
module wkt_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic flag_q
);
  logic clr;

  // Only a written 0 clears; an expiry in the same cycle wins
  assign clr = flag_wr && !flag_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_i) |=> !flag_q);
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_tick,
  input  logic             stop_mode,
  input  logic             ivl_wr,
  input  logic [CNT_W-1:0] ivl_wdata,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             irq_flag,
  output logic             wake_req,
  output logic [CNT_W-1:0] count_val,
  output logic             enabled
);
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] load_val;
  logic             en_q;
  logic             start;
  logic             expire;

  wkt_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ivl_wr    (ivl_wr),
    .ivl_wdata (ivl_wdata),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .reload_q  (reload_q),
    .en_q      (en_q),
    .start     (start),
    .load_val  (load_val)
  );

  wkt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .en_q       (en_q),
    .tick       (ring_tick),
    .load_val   (load_val),
    .reload_val (reload_q),
    .count_q    (count_val),
    .expire     (expire)
  );

  wkt_irq_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (expire),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .flag_q     (irq_flag)
  );

  // Counting ignores stop mode; only the wake request looks at it
  assign wake_req = irq_flag && stop_mode;
  assign enabled  = en_q;

  // R12
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && en_wr && en_wdata && !ring_tick && !expire) |=> $stable(count_val));
endmodule

// File: tb/test_wake_timer.sv
module test_wake_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ring_tick = 1'b0, stop_mode = 1'b0;
  logic         ivl_wr = 1'b0, en_wr = 1'b0, en_wdata = 1'b0;
  logic         flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [W-1:0] ivl_wdata = '0;
  logic         irq_flag, wake_req, enabled;
  logic [W-1:0] count_val;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wake_timer #(.CNT_W(W)) i_wake_timer (
    .clk(clk), .rst_n(rst_n), .ring_tick(ring_tick), .stop_mode(stop_mode),
    .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .irq_flag(irq_flag),
    .wake_req(wake_req), .count_val(count_val), .enabled(enabled)
  );

  // Each entry: {interval, ticks after start, expected count, expected flag}
  localparam int NV = 10;
  localparam logic [48:0] VECS [NV] = '{
    {16'd5,   16'd0,   16'd5,   1'b0},
    {16'd5,   16'd3,   16'd2,   1'b0},
    {16'd5,   16'd5,   16'd5,   1'b1},
    {16'd5,   16'd7,   16'd3,   1'b1},
    {16'd1,   16'd1,   16'd1,   1'b1},
    {16'd1,   16'd4,   16'd1,   1'b1},
    {16'd0,   16'd3,   16'd0,   1'b0},
    {16'd300, 16'd299, 16'd1,   1'b0},
    {16'd300, 16'd600, 16'd300, 1'b1},
    {16'd2,   16'd3,   16'd1,   1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply inputs for one clock, then sample at the following falling edge
  task automatic cyc(input logic t, input logic iw, input logic [W-1:0] iv,
                     input logic ew, input logic ev,
                     input logic fw, input logic fv);
    ring_tick = t; ivl_wr = iw; ivl_wdata = iv;
    en_wr = ew; en_wdata = ev; flag_wr = fw; flag_wdata = fv;
    @(negedge clk);
    ring_tick = 0; ivl_wr = 0; en_wr = 0; flag_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic fresh(input logic [W-1:0] iv);
    cyc(0, 0, '0, 1, 0, 1, 0);  // stop and clear flag
    cyc(0, 1, iv, 0, 0, 0, 0);  // interval
    cyc(0, 0, '0, 1, 1, 0, 0);  // enable
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 count", count_val, 0);
    check("R1 enabled", enabled, 0);
    check("R1 flag", irq_flag, 0);
    check("R1 wake", wake_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 0, '0, 1, 1, 0, 0);
    check("R1 interval zero after reset", count_val, 0);

    // Vector walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      fresh(VECS[i][48:33]);
      if (VECS[i][32:17] == 0) check("R2 start load", count_val, VECS[i][48:33]);
      ticks(int'(VECS[i][32:17]));
      check("R5 vector count", count_val, int'(VECS[i][16:1]));
      check("R4 vector flag", irq_flag, int'(VECS[i][0]));
    end

    // R3 hold without tick
    fresh(16'd10);
    cyc(0, 0, '0, 0, 0, 0, 0); cyc(0, 0, '0, 0, 0, 0, 0);
    check("R3 hold no tick", count_val, 10);
    cyc(1, 0, '0, 0, 0, 0, 0); cyc(0, 0, '0, 0, 0, 0, 0); cyc(1, 0, '0, 0, 0, 0, 0);
    check("R3 sparse ticks", count_val, 8);

    // R2 start with interval written in the same cycle
    cyc(0, 0, '0, 1, 0, 1, 0);
    cyc(0, 1, 16'd7, 1, 1, 0, 0);
    check("R2 same-cycle interval", count_val, 7);

    // R8 interval write while running
    fresh(16'd4);
    ticks(1);
    cyc(0, 1, 16'd6, 0, 0, 0, 0);
    check("R8 count untouched", count_val, 3);
    ticks(3);
    check("R8 new reload", count_val, 6);
    check("R8 flag", irq_flag, 1);

    // R6 freeze and restart
    ticks(1);
    cyc(0, 0, '0, 1, 0, 0, 0);
    ticks(2);
    check("R6 frozen", count_val, 5);
    check("R6 enabled low", enabled, 0);
    cyc(0, 0, '0, 1, 1, 0, 0);
    check("R6 restart reload", count_val, 6);

    // R12 redundant enable, start vs tick
    ticks(1);
    cyc(0, 0, '0, 1, 1, 0, 0);
    check("R12 no restart", count_val, 5);
    cyc(0, 0, '0, 1, 0, 0, 0);
    cyc(1, 0, '0, 1, 1, 0, 0);
    check("R12 start beats tick", count_val, 6);

    // R9 flag write behaviour
    check("R9 flag still set", irq_flag, 1);
    cyc(0, 0, '0, 0, 0, 1, 1);
    check("R9 write 1 ignored", irq_flag, 1);
    cyc(0, 0, '0, 0, 0, 1, 0);
    check("R9 write 0 clears", irq_flag, 0);
    ticks(5);
    check("R9 count before collide", count_val, 1);
    cyc(1, 0, '0, 0, 0, 1, 0);
    check("R9 expiry beats clear", irq_flag, 1);

    // R10 stop mode
    fresh(16'd3);
    stop_mode = 1'b1;
    @(negedge clk);
    check("R10 no wake without flag", wake_req, 0);
    ticks(2);
    check("R10 counts in stop", count_val, 1);
    ticks(1);
    check("R10 wake", wake_req, 1);
    check("R10 refill in stop", count_val, 3);
    stop_mode = 1'b0;
    @(negedge clk);
    check("R10 wake drops", wake_req, 0);
    check("R10 flag kept", irq_flag, 1);

    // R7 interval 0 never flags
    fresh(16'd0);
    ticks(20);
    check("R7 flag", irq_flag, 0);
    check("R7 count", count_val, 0);

    // R11 full interval
    fresh(16'hFFFF);
    ticks(65534);
    check("R11 one before", count_val, 1);
    check("R11 no early flag", irq_flag, 0);
    ticks(1);
    check("R11 flag", irq_flag, 1);
    check("R11 refill", count_val, 65535);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule